// File: doc/BRIEF.md
# Floating-point compare flag unit

This block compares two IEEE-754 operands and turns the outcome into a 4-bit condition-flag value held in a register (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V). A width select picks the operand format. When it is low, the low 32 bits of each operand are read as single precision. When it is high, all 64 bits are read as double precision. Three operation kinds are accepted: register against register, register against positive zero, and conditional compare.

For a conditional compare, a 4-bit condition code is first evaluated against the flags currently held in the register. If the condition holds, the compare result is written. If it fails, a 4-bit immediate is written instead. The register changes only in a cycle where the strobe is high.

Top module: `fcmp_flag_unit`

## Requirements
- R1: After synchronous reset, `flags_q` is 4'b0000.
- R2: `flags_q` changes only on a rising clock edge where `op_valid` is high. With `op_valid` low it holds its value, whatever the other inputs do.
- R3: If either operand is a NaN (exponent all ones and a non-zero fraction, quiet or signalling), the compare result is 4'b0011 (unordered).
- R4: For non-NaN operands, the result is 4'b1000 when A < B, 4'b0010 when A > B, and 4'b0110 when they are equal. Infinities order beyond every finite value.
- R5: +0.0 and -0.0 compare equal, and so give 4'b0110.
- R6: `is_dbl`=0 reads the low 32 bits of each operand as binary32 and ignores the upper 32 bits. `is_dbl`=1 reads all 64 bits as binary64.
- R7: `op_kind` encoding: 2'd0 compares A with B, 2'd1 compares A with +0.0 and ignores B, 2'd2 is conditional compare, and 2'd3 is reserved and leaves `flags_q` unchanged.
- R8: Conditional compare evaluates `cond` on the current `flags_q`. The codes are 0 EQ(Z), 1 NE(!Z), 2 CS(C), 3 CC(!C), 4 MI(N), 5 PL(!N), 6 VS(V), 7 VC(!V), 8 HI(C&!Z), 9 LS(!(C&!Z)), 10 GE(N==V), 11 LT(N!=V), 12 GT(!Z&N==V), 13 LE(!(!Z&N==V)), 14 and 15 always pass. A passing condition writes the compare of A with B.
- R9: A conditional compare whose condition fails writes `imm_flags` into `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Update strobe |
| op_kind | input | 2 | Operation kind |
| is_dbl | input | 1 | 1 = binary64, 0 = binary32 |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| cond | input | 4 | Condition code for conditional compare |
| imm_flags | input | 4 | Flags written when the condition fails |
| flags_q | output | 4 | Registered NZCV flags |

## Verification
The condition evaluation and the flag update fall in the same cycle. A conditional compare reads the flags that the previous operation wrote, while its own result replaces them at the same edge.

The bench provokes this by issuing back-to-back strobed operations with random condition codes, immediates and operands, including NaNs, signed zeros and infinities. Each expected value is computed from the bench's own model of the previous flags. A condition evaluated on stale or freshly written flags therefore shows up as a mismatch.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int DW = 64;
    localparam int SW = 32;
    localparam int FW = 4;

    typedef enum logic [1:0] {
        K_REG  = 2'd0,
        K_ZERO = 2'd1,
        K_COND = 2'd2,
        K_RSVD = 2'd3
    } kind_e;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_zero;
        logic [62:0] mag;
    } fp_view_t;

    localparam logic [FW-1:0] FL_UNORD = 4'b0011;
    localparam logic [FW-1:0] FL_LESS  = 4'b1000;
    localparam logic [FW-1:0] FL_EQUAL = 4'b0110;
    localparam logic [FW-1:0] FL_GREAT = 4'b0010;

    function automatic fp_view_t view_dbl(input logic [DW-1:0] v);
        fp_view_t r;
        r.sign    = v[63];
        r.mag     = v[62:0];
        r.is_nan  = (&v[62:52]) && (|v[51:0]);
        r.is_zero = (v[62:0] == '0);
        return r;
    endfunction

    function automatic fp_view_t view_sgl(input logic [SW-1:0] v);
        fp_view_t r;
        r.sign    = v[31];
        r.mag     = {32'd0, v[30:0]};
        r.is_nan  = (&v[30:23]) && (|v[22:0]);
        r.is_zero = (v[30:0] == '0);
        return r;
    endfunction
endpackage

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          dbl,
    output logic [FW-1:0] res
);
    fp_view_t va, vb;
    logic a_lt_b, a_gt_b;

    always_comb begin
        if (dbl) begin
            va = view_dbl(a);
            vb = view_dbl(b);
        end else begin
            va = view_sgl(a[SW-1:0]);
            vb = view_sgl(b[SW-1:0]);
        end
    end

    // Sign-magnitude ordering; equal zeros of either sign are handled first.
    always_comb begin
        a_lt_b = 1'b0;
        a_gt_b = 1'b0;
        if (!(va.is_zero && vb.is_zero)) begin
            if (va.sign != vb.sign) begin
                a_lt_b = va.sign;
                a_gt_b = vb.sign;
            end else if (va.mag != vb.mag) begin
                a_lt_b = (va.mag < vb.mag) ^ va.sign;
                a_gt_b = !a_lt_b;
            end
        end
        if (va.is_nan || vb.is_nan) res = FL_UNORD;
        else if (a_lt_b)            res = FL_LESS;
        else if (a_gt_b)            res = FL_GREAT;
        else                        res = FL_EQUAL;
    end

    always_comb begin
        a_r4_exclusive: assert (!(a_lt_b && a_gt_b));
    end
endmodule

// File: rtl/fcmp_cond_eval.sv
module fcmp_cond_eval
    import fcmp_pkg::*;
(
    input  logic [FW-1:0] nzcv,
    input  logic [3:0]    cc,
    output logic          pass
);
    logic n, z, c, v, base;
    assign {n, z, c, v} = nzcv;

    always_comb begin
        case (cc[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c && !z;
            3'd5: base = (n == v);
            3'd6: base = !z && (n == v);
            default: base = 1'b1;
        endcase
        pass = (cc[3:1] == 3'd7) ? 1'b1 : (base ^ cc[0]);
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic          is_dbl,
    input  logic [63:0]   opa,
    input  logic [63:0]   opb,
    input  logic [3:0]    cond,
    input  logic [3:0]    imm_flags,
    output logic [3:0]    flags_q
);
    kind_e         kind;
    logic [DW-1:0] rhs;
    logic [FW-1:0] cmp_res, next_flags;
    logic          cc_pass, do_write;

    assign kind = kind_e'(op_kind);
    assign rhs  = (kind == K_ZERO) ? '0 : opb;

    fcmp_order u_order (.a(opa), .b(rhs), .dbl(is_dbl), .res(cmp_res));
    fcmp_cond_eval u_cond (.nzcv(flags_q), .cc(cond), .pass(cc_pass));

    always_comb begin
        do_write   = op_valid && (kind != K_RSVD);
        next_flags = cmp_res;
        if (kind == K_COND && !cc_pass) next_flags = imm_flags;
    end

    always_ff @(posedge clk) begin
        if (rst)           flags_q <= '0;
        else if (do_write) flags_q <= next_flags;
    end

    a_r1_reset: assert property (@(posedge clk) rst |=> flags_q == 4'b0000);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(flags_q));
    a_r7_rsvd: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd3) |=> $stable(flags_q));
    a_r3_legal: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind != 2'd2) |=> (flags_q == FL_UNORD || flags_q == FL_LESS
                                          || flags_q == FL_EQUAL || flags_q == FL_GREAT
                                          || op_kind == 2'd3 || $past(op_kind) == 2'd3));
    a_r9_fail_imm: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd2 && !cc_pass) |=> flags_q == $past(imm_flags));
endmodule

// File: tb/fcmp_flag_unit_test.sv
module fcmp_flag_unit_test;
    logic clk = 0, rst = 1, op_valid = 0, is_dbl = 0;
    logic [1:0] op_kind = 0;
    logic [63:0] opa = 0, opb = 0;
    logic [3:0] cond = 0, imm_flags = 0;
    logic [3:0] flags_q;
    logic [3:0] model = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fcmp_flag_unit uut (.*);

    function automatic bit nan_of(input logic [63:0] v, input bit d);
        if (d) return (&v[62:52]) && (|v[51:0]);
        return (&v[30:23]) && (|v[22:0]);
    endfunction

    function automatic real val_of(input logic [63:0] v, input bit d);
        if (d) return $bitstoreal(v);
        return $bitstoreal({v[31], {3{v[30] ^ 1'b0}} & 3'b000, 60'd0}) * 0.0
               + sgl_real(v[31:0]);
    endfunction

    function automatic real sgl_real(input logic [31:0] s);
        logic [63:0] d;
        int e;
        if (s[30:23] == 8'hFF) d = {s[31], 11'h7FF, s[22:0], 29'd0};
        else if (s[30:23] == 0) return (s[31] ? -1.0 : 1.0) * s[22:0] * (2.0 ** -149);
        else begin
            e = s[30:23] - 127 + 1023;
            d = {s[31], 11'(e), s[22:0], 29'd0};
        end
        return $bitstoreal(d);
    endfunction

    function automatic logic [3:0] cmp_of(input logic [63:0] a, input logic [63:0] b, input bit d);
        real ra, rb;
        if (nan_of(a, d) || nan_of(b, d)) return 4'b0011;
        ra = val_of(a, d);
        rb = val_of(b, d);
        if (ra < rb) return 4'b1000;
        if (ra > rb) return 4'b0010;
        return 4'b0110;
    endfunction

    function automatic bit cc_ok(input logic [3:0] f, input logic [3:0] c);
        bit n, z, cy, v, r;
        {n, z, cy, v} = f;
        case (c)
            0: r = z;  1: r = !z;  2: r = cy;  3: r = !cy;
            4: r = n;  5: r = !n;  6: r = v;   7: r = !v;
            8: r = cy && !z;  9: r = !(cy && !z);
            10: r = n == v;   11: r = n != v;
            12: r = !z && n == v;  13: r = !(!z && n == v);
            default: r = 1;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (flags_q !== exp) begin
            fails++;
            $display("FAIL %s: flags_q=%b expected=%b", req, flags_q, exp);
        end
    endtask

    task automatic issue(input bit v, input logic [1:0] k, input bit d, input logic [63:0] a,
                         input logic [63:0] b, input logic [3:0] c, input logic [3:0] im,
                         input string req);
        @(negedge clk);
        op_valid = v; op_kind = k; is_dbl = d; opa = a; opb = b; cond = c; imm_flags = im;
        if (v) begin
            case (k)
                2'd0: model = cmp_of(a, b, d);
                2'd1: model = cmp_of(a, 64'd0, d);
                2'd2: model = cc_ok(model, c) ? cmp_of(a, b, d) : im;
                default: ;
            endcase
        end
        @(negedge clk);
        op_valid = 0;
        check(req, model);
    endtask

    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DM1 = 64'hBFF0000000000000, DNEGZ = 64'h8000000000000000;
    localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;
    localparam logic [63:0] DINF = 64'h7FF0000000000000;

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog: expired, expected completion");
        done = 1;
    end

    initial begin
        logic [63:0] pool [10];
        repeat (3) @(negedge clk);
        check("R1", 4'b0000);
        rst = 0;
        issue(1, 0, 1, D1, D2, 0, 0, "R4 less");
        issue(1, 0, 1, D2, D1, 0, 0, "R4 greater");
        issue(1, 0, 1, D1, D1, 0, 0, "R4 equal");
        issue(1, 0, 1, DINF, D2, 0, 0, "R4 inf");
        issue(1, 0, 1, DQN, D1, 0, 0, "R3 qnan");
        issue(1, 0, 1, D1, DSN, 0, 0, "R3 snan");
        issue(1, 0, 1, DNEGZ, 64'd0, 0, 0, "R5 zeros");
        issue(1, 1, 1, DM1, DQN, 0, 0, "R7 zero-kind ignores B");
        issue(1, 0, 0, {32'h7FF80000, 32'h3F800000}, {32'h0, 32'h40000000}, 0, 0, "R6 single");
        issue(1, 0, 0, 64'h0, 64'h7FC00000, 0, 0, "R6 single nan");
        issue(0, 0, 1, D1, D2, 0, 0, "R2 hold");
        issue(1, 3, 1, D1, D2, 0, 0, "R7 reserved");
        issue(1, 0, 1, D1, D1, 0, 0, "R4 set Z");
        issue(1, 2, 1, D1, D2, 0, 4'b1111, "R8 EQ pass");
        issue(1, 2, 1, D1, D2, 0, 4'b0101, "R9 EQ fail imm");
        issue(1, 2, 1, D1, D2, 15, 4'b1111, "R8 NV pass");
        void'($urandom(32'd1234));
        pool = '{D1, D2, DM1, DNEGZ, 64'd0, DQN, DSN, DINF, 64'hFFF0000000000000, 64'h3FF0000000000001};
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            bit d;
            d = $urandom_range(0, 1);
            a = ($urandom_range(0, 2) == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 9)];
            b = ($urandom_range(0, 2) == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 9)];
            if (!d && $urandom_range(0, 1)) begin
                a = {$urandom, 1'b0, 8'($urandom_range(120, 130)), 23'($urandom)};
                b = {$urandom, 1'b0, 8'($urandom_range(120, 130)), 23'($urandom)};
            end
            issue($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), d, a, b,
                  4'($urandom), 4'($urandom), "R8 R9 R2 random");
        end
        done = 1;
    end

    always @(posedge clk) if (done) begin
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule